// File: doc/BRIEF.md
# Instrument Bus Listener and Address Decoder

This block is the device-side front end of a byte-wide instrument bus. All bus lines are active low. The block takes part in the three-wire byte handshake as an acceptor. It reads each byte the active talker offers. Bytes offered while the attention line is asserted are decoded as interface commands. From these commands the block keeps the device's listener, talker, remote, lockout and serial-poll states. It also emits one-cycle pulses for device clear and trigger. Bytes offered while attention is deasserted go to the device as data, but only when the device is addressed to listen.

The bus inputs pass through a two-stage synchronizer first. The acceptor is a four-state machine:

- `ACC_OFF`: both handshake pulls are released.
- `ACC_WAIT`: not ready, so both lines are pulled.
- `ACC_READY`: NRFD is released and NDAC is held.
- `ACC_HOLD`: the byte has been taken, so NRFD is pulled and NDAC is released.

The acceptor has six transitions:

- `OFF->WAIT` when the block becomes involved, that is, attention is asserted or the device is a listener.
- `WAIT->READY` when the device is ready and DAV is clear.
- `READY->HOLD` on the first synchronized DAV.
- `READY->WAIT` when readiness drops.
- `HOLD->WAIT` or `HOLD->OFF` when DAV clears.
- `any->OFF` when the block stops being involved.

Commands are always accepted regardless of device readiness. The device supplies a status byte whenever it is the talker in serial-poll mode.

Top module: `instr_bus_listener`

## Requirements
- R1: While involved, the block releases NRFD only while it also pulls NDAC. In `ACC_READY` it releases NRFD only if `accept_rdy` is high or attention is asserted. After it sees DAV, it pulls NRFD and then releases NDAC, and it keeps that state until DAV clears.
- R2: With attention deasserted and the device not a listener, both pulls stay released and a DAV strobe produces no `rx_vld`.
- R3: The command 0x20 plus `own_addr` makes the device a listener and clears talker. The command 0x3F clears listener.
- R4: The command 0x40 plus `own_addr` makes the device a talker and clears listener. Any other code from 0x40 to 0x5F, including 0x5F, clears talker.
- R5: When `own_addr` is 31, no code matches the device's own listen or talk address.
- R6: A listen address received while REN is asserted sets remote mode. REN deasserted clears remote mode and lockout within three clocks. This holds even when the deassertion meets a listen address in the same cycle.
- R7: Once 0x11 has been received with REN asserted, entering remote mode also sets `local_lockout`. The lockout stays set, even through go-to-local, until REN is deasserted.
- R8: The command 0x01 clears remote mode only if the device is a listener at that moment.
- R9: The command 0x14 always gives one `dev_clr_pulse`. The command 0x04 gives one `dev_clr_pulse` and the command 0x08 gives one `trig_pulse`, each only if the device is a listener. Each pulse lasts exactly one clock.
- R10: The command 0x18 sets serial-poll mode and 0x19 clears it. `talk_vld` is high exactly when the device is both talker and in serial-poll mode. In that case `talk_byte` is {dev_status[6], svc_req, dev_status[5:0]}, so bit 6 carries the service request.
- R11: IFC low clears listener and talker asynchronously, without waiting for a clock edge.
- R12: A data byte accepted while the device is a listener and attention is deasserted appears on `rx_data` as the inverse of the data lines, with a one-clock `rx_vld`. Command decoding uses bits 6:0 only, so bit 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_dio_n | input | 8 | Data lines, active low |
| bus_dav_n | input | 1 | Data valid, active low |
| bus_atn_n | input | 1 | Attention, active low |
| bus_ifc_n | input | 1 | Interface clear, active low, asynchronous |
| bus_ren_n | input | 1 | Remote enable, active low |
| own_addr | input | 5 | Device address; 31 means no address |
| accept_rdy | input | 1 | Device can take a data byte |
| svc_req | input | 1 | Device's own service request |
| dev_status | input | 7 | Other status bits for the poll byte |
| nrfd_pull | output | 1 | 1 = pull NRFD low |
| ndac_pull | output | 1 | 1 = pull NDAC low |
| rx_data | output | 8 | Received data byte |
| rx_vld | output | 1 | One-clock strobe for rx_data |
| is_listener | output | 1 | Addressed to listen |
| is_talker | output | 1 | Addressed to talk |
| remote_mode | output | 1 | Remote control active |
| local_lockout | output | 1 | Local return disabled |
| spoll_mode | output | 1 | Serial-poll mode |
| talk_byte | output | 8 | Status byte to send |
| talk_vld | output | 1 | talk_byte is to be sent |
| dev_clr_pulse | output | 1 | Device clear strobe |
| trig_pulse | output | 1 | Trigger strobe |

## Verification
Two updates can fall in the same clock. One is the REN-release path that clears the remote state. The other is the decode of a listen address that would set it. The bench provokes this by releasing REN on the same edge that it asserts DAV for the device's listen address. Both changes cross the synchronizer together, so the decode sees REN already deasserted. The expected result is a listener with remote mode clear, and the reference model is checked against it on every following clock.

// File: rtl/ibl_pkg.sv
`timescale 1ns/1ps
package ibl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int CMD_W  = 7;
    localparam int GRP_W  = CMD_W - ADDR_W;

    localparam logic [ADDR_W-1:0] RSV_ADDR   = '1;
    localparam logic [GRP_W-1:0]  GRP_LISTEN = 2'b01;
    localparam logic [GRP_W-1:0]  GRP_TALK   = 2'b10;

    localparam logic [CMD_W-1:0] CMD_GTL = 7'h01;
    localparam logic [CMD_W-1:0] CMD_SDC = 7'h04;
    localparam logic [CMD_W-1:0] CMD_GET = 7'h08;
    localparam logic [CMD_W-1:0] CMD_LLO = 7'h11;
    localparam logic [CMD_W-1:0] CMD_DCL = 7'h14;
    localparam logic [CMD_W-1:0] CMD_SPE = 7'h18;
    localparam logic [CMD_W-1:0] CMD_SPD = 7'h19;
    localparam logic [CMD_W-1:0] CMD_UNL = 7'h3F;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_WAIT  = 2'd1,
        ACC_READY = 2'd2,
        ACC_HOLD  = 2'd3
    } acc_state_t;
endpackage

// File: rtl/ibl_sync.sv
`timescale 1ns/1ps
module ibl_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ibl_acceptor.sv
`timescale 1ns/1ps
module ibl_acceptor
    import ibl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ready,
    input  logic              dav_s,
    input  logic              atn_s,
    input  logic [DATA_W-1:0] data_n_s,
    output logic              nrfd_pull,
    output logic              ndac_pull,
    output logic              byte_stb,
    output logic              byte_atn,
    output logic [DATA_W-1:0] byte_q
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_OFF:   if (active) state_d = ACC_WAIT;
            ACC_WAIT: begin
                if (!active)               state_d = ACC_OFF;
                else if (ready && !dav_s)  state_d = ACC_READY;
            end
            ACC_READY: begin
                if (!active)      state_d = ACC_OFF;
                else if (dav_s)   state_d = ACC_HOLD;
                else if (!ready)  state_d = ACC_WAIT;
            end
            ACC_HOLD:  if (!dav_s) state_d = active ? ACC_WAIT : ACC_OFF;
            default:   state_d = ACC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        nrfd_pull = 1'b0;
        ndac_pull = 1'b0;
        unique case (state_q)
            ACC_OFF:   begin nrfd_pull = 1'b0; ndac_pull = 1'b0; end
            ACC_WAIT:  begin nrfd_pull = 1'b1; ndac_pull = 1'b1; end
            ACC_READY: begin nrfd_pull = 1'b0; ndac_pull = 1'b1; end
            ACC_HOLD:  begin nrfd_pull = 1'b1; ndac_pull = 1'b0; end
            default:   begin nrfd_pull = 1'b0; ndac_pull = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_stb <= 1'b0;
            byte_atn <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (state_q == ACC_READY && active && dav_s) begin
                byte_stb <= 1'b1;
                byte_atn <= atn_s;
                byte_q   <= ~data_n_s;
            end
        end
    end
endmodule

// File: rtl/ibl_decoder.sv
`timescale 1ns/1ps
module ibl_decoder
    import ibl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              role_clr_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ren_s,
    input  logic              byte_stb,
    input  logic              byte_atn,
    input  logic [DATA_W-1:0] byte_q,
    output logic              lstn,
    output logic              tlkr,
    output logic              remote,
    output logic              lockout,
    output logic              spoll,
    output logic              clr_pulse,
    output logic              trig_pulse,
    output logic              rx_vld,
    output logic [DATA_W-1:0] rx_data
);
    logic [CMD_W-1:0] cmd;
    logic is_cmd, addr_ok, hit_listen, hit_talk, other_talk, unlisten;
    logic llo_armed;

    always_comb begin
        cmd        = byte_q[CMD_W-1:0];
        is_cmd     = byte_stb && byte_atn;
        addr_ok    = (own_addr != RSV_ADDR);
        hit_listen = is_cmd && addr_ok && (cmd == {GRP_LISTEN, own_addr});
        hit_talk   = is_cmd && addr_ok && (cmd == {GRP_TALK, own_addr});
        other_talk = is_cmd && (cmd[CMD_W-1:ADDR_W] == GRP_TALK) && !hit_talk;
        unlisten   = is_cmd && (cmd == CMD_UNL);
    end

    always_ff @(posedge clk or negedge role_clr_n) begin
        if (!role_clr_n) begin
            lstn <= 1'b0;
            tlkr <= 1'b0;
        end else if (hit_listen) begin
            lstn <= 1'b1;
            tlkr <= 1'b0;
        end else if (hit_talk) begin
            tlkr <= 1'b1;
            lstn <= 1'b0;
        end else begin
            if (unlisten)   lstn <= 1'b0;
            if (other_talk) tlkr <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remote    <= 1'b0;
            lockout   <= 1'b0;
            llo_armed <= 1'b0;
        end else if (!ren_s) begin
            remote    <= 1'b0;
            lockout   <= 1'b0;
            llo_armed <= 1'b0;
        end else if (is_cmd) begin
            if (hit_listen) begin
                remote <= 1'b1;
                if (llo_armed) lockout <= 1'b1;
            end
            if (cmd == CMD_GTL && lstn) remote <= 1'b0;
            if (cmd == CMD_LLO) llo_armed <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spoll      <= 1'b0;
            clr_pulse  <= 1'b0;
            trig_pulse <= 1'b0;
            rx_vld     <= 1'b0;
            rx_data    <= '0;
        end else begin
            if (is_cmd && cmd == CMD_SPE) spoll <= 1'b1;
            if (is_cmd && cmd == CMD_SPD) spoll <= 1'b0;
            clr_pulse  <= is_cmd && (cmd == CMD_DCL || (cmd == CMD_SDC && lstn));
            trig_pulse <= is_cmd && cmd == CMD_GET && lstn;
            rx_vld     <= byte_stb && !byte_atn && lstn;
            if (byte_stb && !byte_atn) rx_data <= byte_q;
        end
    end
endmodule

// File: rtl/instr_bus_listener.sv
`timescale 1ns/1ps
module instr_bus_listener
    import ibl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_dio_n,
    input  logic              bus_dav_n,
    input  logic              bus_atn_n,
    input  logic              bus_ifc_n,
    input  logic              bus_ren_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              accept_rdy,
    input  logic              svc_req,
    input  logic [DATA_W-2:0] dev_status,
    output logic              nrfd_pull,
    output logic              ndac_pull,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_vld,
    output logic              is_listener,
    output logic              is_talker,
    output logic              remote_mode,
    output logic              local_lockout,
    output logic              spoll_mode,
    output logic [DATA_W-1:0] talk_byte,
    output logic              talk_vld,
    output logic              dev_clr_pulse,
    output logic              trig_pulse
);
    localparam int SW = DATA_W + 3;

    logic [SW-1:0]     sync_q;
    logic [DATA_W-1:0] data_n_s;
    logic dav_s, atn_s, ren_s;
    logic acc_active, acc_ready, role_clr_n;
    logic byte_stb, byte_atn;
    logic [DATA_W-1:0] byte_q;

    ibl_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_dio_n, bus_dav_n, bus_atn_n, bus_ren_n}),
        .q     (sync_q)
    );

    assign data_n_s   = sync_q[SW-1:3];
    assign dav_s      = !sync_q[2];
    assign atn_s      = !sync_q[1];
    assign ren_s      = !sync_q[0];
    assign acc_active = atn_s || is_listener;
    assign acc_ready  = atn_s || accept_rdy;
    assign role_clr_n = rst_n && bus_ifc_n;

    ibl_acceptor u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (acc_active),
        .ready     (acc_ready),
        .dav_s     (dav_s),
        .atn_s     (atn_s),
        .data_n_s  (data_n_s),
        .nrfd_pull (nrfd_pull),
        .ndac_pull (ndac_pull),
        .byte_stb  (byte_stb),
        .byte_atn  (byte_atn),
        .byte_q    (byte_q)
    );

    ibl_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .role_clr_n (role_clr_n),
        .own_addr   (own_addr),
        .ren_s      (ren_s),
        .byte_stb   (byte_stb),
        .byte_atn   (byte_atn),
        .byte_q     (byte_q),
        .lstn       (is_listener),
        .tlkr       (is_talker),
        .remote     (remote_mode),
        .lockout    (local_lockout),
        .spoll      (spoll_mode),
        .clr_pulse  (dev_clr_pulse),
        .trig_pulse (trig_pulse),
        .rx_vld     (rx_vld),
        .rx_data    (rx_data)
    );

    assign talk_vld  = is_talker && spoll_mode;
    assign talk_byte = {dev_status[DATA_W-2], svc_req, dev_status[DATA_W-3:0]};
endmodule

// File: rtl/ibl_chk.sv
`timescale 1ns/1ps
module ibl_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_active,
    input logic nrfd_pull,
    input logic ndac_pull,
    input logic is_listener,
    input logic is_talker,
    input logic ren_s,
    input logic remote_mode,
    input logic local_lockout,
    input logic dev_clr_pulse,
    input logic trig_pulse,
    input logic bus_ifc_n
);
    // R1
    nrfd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nrfd_pull) && $past(acc_active)) |-> ndac_pull);
    // R1
    ndac_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ndac_pull) && $past(acc_active)) |-> nrfd_pull);
    // R3
    role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_listener && is_talker));
    // R6
    ren_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_s |=> (!remote_mode && !local_lockout));
    // R7
    lockout_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_lockout) |-> remote_mode);
    // R9
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr_pulse |=> !dev_clr_pulse);
    // R9
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    // R11
    ifc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ifc_n |-> (!is_listener && !is_talker));
endmodule

bind instr_bus_listener ibl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_active    (acc_active),
    .nrfd_pull     (nrfd_pull),
    .ndac_pull     (ndac_pull),
    .is_listener   (is_listener),
    .is_talker     (is_talker),
    .ren_s         (ren_s),
    .remote_mode   (remote_mode),
    .local_lockout (local_lockout),
    .dev_clr_pulse (dev_clr_pulse),
    .trig_pulse    (trig_pulse),
    .bus_ifc_n     (bus_ifc_n)
);

// File: tb/instr_bus_listener_tb_top.sv
`timescale 1ns/1ps
module instr_bus_listener_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_dio_n = 8'hFF;
    logic bus_dav_n = 1'b1, bus_atn_n = 1'b1, bus_ifc_n = 1'b1, bus_ren_n = 1'b1;
    logic [4:0] own_addr = 5'd5;
    logic accept_rdy = 1'b1, svc_req = 1'b0;
    logic [6:0] dev_status = 7'h0F;
    logic nrfd_pull, ndac_pull, rx_vld, is_listener, is_talker;
    logic remote_mode, local_lockout, spoll_mode, talk_vld, dev_clr_pulse, trig_pulse;
    logic [7:0] rx_data, talk_byte;

    always #2 clk = ~clk;

    instr_bus_listener dut_i (
        .clk(clk), .rst_n(rst_n), .bus_dio_n(bus_dio_n), .bus_dav_n(bus_dav_n),
        .bus_atn_n(bus_atn_n), .bus_ifc_n(bus_ifc_n), .bus_ren_n(bus_ren_n),
        .own_addr(own_addr), .accept_rdy(accept_rdy), .svc_req(svc_req),
        .dev_status(dev_status), .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull),
        .rx_data(rx_data), .rx_vld(rx_vld), .is_listener(is_listener),
        .is_talker(is_talker), .remote_mode(remote_mode), .local_lockout(local_lockout),
        .spoll_mode(spoll_mode), .talk_byte(talk_byte), .talk_vld(talk_vld),
        .dev_clr_pulse(dev_clr_pulse), .trig_pulse(trig_pulse)
    );

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    bit m_lstn, m_tlkr, m_rem, m_lock, m_armed, m_spoll;
    int clr_cnt = 0, trig_cnt = 0, rx_cnt = 0;
    int exp_clr = 0, exp_trig = 0, exp_rx = 0;
    logic [7:0] exp_rx_data = 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    always @(negedge clk) if (rst_n) begin
        if (dev_clr_pulse) clr_cnt++;
        if (trig_pulse) trig_cnt++;
        if (rx_vld) rx_cnt++;
    end

    // Reference model compared on every clock while the bus is settled
    always @(negedge clk) if (cmp_en) begin
        chk("R3 listener", is_listener, m_lstn);
        chk("R4 talker", is_talker, m_tlkr);
        chk("R6 remote", remote_mode, m_rem);
        chk("R7 lockout", local_lockout, m_lock);
        chk("R10 spoll", spoll_mode, m_spoll);
        chk("R10 talk_vld", talk_vld, m_tlkr && m_spoll);
        if (m_tlkr && m_spoll)
            chk("R10 talk_byte", talk_byte, {dev_status[6], svc_req, dev_status[5:0]});
    end

    task automatic model_cmd(input logic [7:0] b);
        int c;
        bit ok;
        bit ren;
        c = b & 8'h7F;
        ok = (own_addr != 5'd31);
        ren = !bus_ren_n;
        if (!ren) begin m_rem = 0; m_lock = 0; m_armed = 0; end
        if (ok && c == 32 + own_addr) begin
            m_lstn = 1; m_tlkr = 0;
            if (ren) begin m_rem = 1; if (m_armed) m_lock = 1; end
        end else if (c == 'h3F) m_lstn = 0;
        else if (ok && c == 64 + own_addr) begin m_tlkr = 1; m_lstn = 0; end
        else if (c >= 'h40 && c <= 'h5F) m_tlkr = 0;
        else if (c == 'h01) begin if (m_lstn && ren) m_rem = 0; end
        else if (c == 'h11) begin if (ren) m_armed = 1; end
        else if (c == 'h14) exp_clr++;
        else if (c == 'h04) begin if (m_lstn) exp_clr++; end
        else if (c == 'h08) begin if (m_lstn) exp_trig++; end
        else if (c == 'h18) m_spoll = 1;
        else if (c == 'h19) m_spoll = 0;
    endtask

    task automatic xfer(input logic [7:0] b, input bit atn, input bit drop_ren);
        int t;
        cmp_en = 0;
        @(negedge clk);
        bus_atn_n = !atn;
        bus_dio_n = ~b;
        t = 0;
        while (!(nrfd_pull == 1'b0 && ndac_pull == 1'b1) && t < 50) begin @(negedge clk); t++; end
        chk("R1 ready before DAV", t < 50, 1);
        bus_dav_n = 0;
        if (drop_ren) bus_ren_n = 1;
        t = 0;
        while (ndac_pull != 1'b0 && t < 50) begin @(negedge clk); t++; end
        chk("R1 NDAC released", t < 50, 1);
        chk("R1 NRFD pulled on accept", nrfd_pull, 1);
        repeat (3) @(negedge clk);
        chk("R1 hold while DAV", {nrfd_pull, ndac_pull}, 2'b10);
        if (atn) model_cmd(b);
        else if (m_lstn) begin exp_rx++; exp_rx_data = b; end
        bus_dav_n = 1;
        repeat (6) @(negedge clk);
        cmp_en = 1;
    endtask

    task automatic cmd(input logic [7:0] b);
        xfer(b, 1'b1, 1'b0);
    endtask

    task automatic set_ren(input bit v);
        cmp_en = 0;
        @(negedge clk);
        bus_ren_n = !v;
        repeat (4) @(negedge clk);
        if (!v) begin m_rem = 0; m_lock = 0; m_armed = 0; end
        cmp_en = 1;
    endtask

    task automatic atn_off();
        cmp_en = 0;
        @(negedge clk);
        bus_atn_n = 1;
        repeat (5) @(negedge clk);
        cmp_en = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R2 reset nrfd", nrfd_pull, 0);
        chk("R2 reset ndac", ndac_pull, 0);
        chk("R3 reset listener", is_listener, 0);
        chk("R10 reset talk_vld", talk_vld, 0);
        cmp_en = 1;

        // R3 listen / unlisten, R12 data path
        cmd(8'h25);
        xfer(8'hA5, 1'b0, 1'b0);
        chk("R12 rx count", rx_cnt, exp_rx);
        chk("R12 rx data", rx_data, exp_rx_data);
        cmd(8'h3F);
        atn_off();

        // R4 talker transitions
        cmd(8'h45);
        cmd(8'h25);
        cmd(8'h45);
        cmd(8'h47);
        cmd(8'h45);
        cmd(8'h5F);

        // R12 bit 7 ignored in commands
        cmd(8'hA5);
        chk("R12 bit7 ignored", is_listener, 1);
        cmd(8'h3F);

        // R1 readiness gating of NRFD for data
        cmd(8'h25);
        cmp_en = 0;
        @(negedge clk);
        accept_rdy = 0;
        bus_atn_n = 1;
        repeat (8) @(negedge clk);
        chk("R1 not ready holds NRFD", {nrfd_pull, ndac_pull}, 2'b11);
        accept_rdy = 1;
        repeat (6) @(negedge clk);
        chk("R1 ready releases NRFD", {nrfd_pull, ndac_pull}, 2'b01);
        cmp_en = 1;
        xfer(8'h3C, 1'b0, 1'b0);
        chk("R12 rx data 2", rx_data, exp_rx_data);
        cmd(8'h3F);
        atn_off();

        // R2 data with no involvement
        @(negedge clk);
        bus_dio_n = ~8'h33;
        bus_dav_n = 0;
        repeat (8) @(negedge clk);
        chk("R2 pulls released", {nrfd_pull, ndac_pull}, 2'b00);
        bus_dav_n = 1;
        repeat (4) @(negedge clk);
        chk("R2 no rx", rx_cnt, exp_rx);

        // R6 remote enter and leave
        set_ren(1);
        cmd(8'h25);
        chk("R6 remote set", remote_mode, 1);
        set_ren(0);
        chk("R6 remote cleared", remote_mode, 0);

        // R7 lockout, R8 go-to-local while listener
        set_ren(1);
        cmd(8'h3F);
        cmd(8'h11);
        cmd(8'h25);
        chk("R7 lockout set", local_lockout, 1);
        cmd(8'h01);
        chk("R8 gtl listener", remote_mode, 0);
        chk("R7 lockout kept", local_lockout, 1);
        set_ren(0);
        chk("R7 lockout cleared", local_lockout, 0);

        // R8 go-to-local ignored when not listener
        set_ren(1);
        cmd(8'h25);
        cmd(8'h3F);
        cmd(8'h01);
        chk("R8 gtl not listener", remote_mode, 1);
        set_ren(0);

        // R9 clears and trigger
        cmd(8'h14);
        cmd(8'h04);
        cmd(8'h08);
        chk("R9 clr unaddressed", clr_cnt, exp_clr);
        chk("R9 trig unaddressed", trig_cnt, exp_trig);
        cmd(8'h25);
        cmd(8'h04);
        cmd(8'h08);
        chk("R9 clr addressed", clr_cnt, exp_clr);
        chk("R9 trig addressed", trig_cnt, exp_trig);
        cmd(8'h3F);

        // R10 serial poll
        cmd(8'h18);
        cmd(8'h45);
        @(negedge clk);
        svc_req = 1;
        @(negedge clk);
        chk("R10 srq byte", talk_byte, 8'h4F);
        svc_req = 0;
        @(negedge clk);
        chk("R10 no srq byte", talk_byte, 8'h0F);
        cmd(8'h19);
        chk("R10 spd", talk_vld, 0);

        // R11 asynchronous interface clear
        cmd(8'h25);
        cmp_en = 0;
        @(negedge clk);
        #0.4 bus_ifc_n = 0;
        #0.4 chk("R11 async clear", is_listener, 0);
        @(negedge clk);
        bus_ifc_n = 1;
        m_lstn = 0; m_tlkr = 0;
        repeat (2) @(negedge clk);
        cmp_en = 1;

        // R5 reserved own address
        own_addr = 5'd31;
        cmd(8'h5F);
        chk("R5 no talk at 31", is_talker, 0);
        cmd(8'h3F);
        chk("R5 no listen at 31", is_listener, 0);
        own_addr = 5'd5;

        // R6 REN release meets listen address decode
        set_ren(1);
        xfer(8'h25, 1'b1, 1'b1);
        chk("R6 concurrent listener", is_listener, 1);
        chk("R6 concurrent remote", remote_mode, 0);
        atn_off();

        repeat (4) @(negedge clk);
        report();
    end
endmodule